// File: doc/BRIEF.md
# Byte-Framed Serial Debug Message Receiver

This block is the receiving half of a half-duplex synchronous serial debug port. A host controller that behaves like an SPI mode 0 master pulls an active-low write strobe low and then clocks whole bytes in, most significant bit first. Each data bit is taken on a rising edge of the serial clock. When the strobe returns high, the block classifies the frame and acts on it. Classification uses the number of complete bytes received and the last byte, which serves as a signature.

The block understands three messages:

- **Null frame.** The strobe goes low and then high with no serial clock edges. This returns the chain selector to its idle value.
- **Select frame.** This frame is two bytes long and chooses one of six scan sub-chains. Choosing chain one also raises the port's internal reset strobe.
- **Execute frame.** This frame is four bytes long. It loads a 16-bit instruction word and an 8-bit command byte for the core, and it announces them with a single-cycle pulse.

All pins are sampled into one system clock through synchronizer stages. Every edge is detected in that clock domain.

Top module: `dbg_msg_rx`

## Requirements
- R1: After reset, `chain_sel` is 0, `port_rst` is 0, `instr` is 0, `cmd` is 0 and `exec_pulse` is 0.
- R2: A rising edge of `sclk` adds the `sdi` level to the frame only while `wr_n` is low. The first bit of each byte is its bit 7. Edges of `sclk` while `wr_n` is high change no output.
- R3: A frame with no `sclk` rising edge between the fall and the rise of `wr_n` sets `chain_sel` to 0 and clears `port_rst`.
- R4: A frame of exactly two bytes with a second byte of 0x53 and a first byte from 0x31 to 0x36 sets `chain_sel` to the first byte minus 0x30.
- R5: A valid select frame with first byte 0x31 sets `port_rst` to 1. `port_rst` then stays 1 through any other frame until a null frame arrives.
- R6: A frame of exactly four bytes whose fourth byte is 0x58 loads `instr` with {byte1, byte2} and `cmd` with byte3. It also gives exactly one `exec_pulse` of one clock cycle, whatever the current `chain_sel` value.
- R7: A frame with any other byte count, any other last byte, or a select digit outside 0x31 to 0x36 leaves `chain_sel`, `port_rst`, `instr` and `cmd` unchanged and gives no `exec_pulse`.
- R8: Bits after the last complete byte are discarded. A frame that holds only 1 to 7 clocked bits is not a null frame and changes nothing.
- R9: `instr` and `cmd` change only in the cycle in which `exec_pulse` is high. `exec_pulse` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| wr_n | input | 1 | Active-low write strobe that frames a message |
| sdi | input | 1 | Serial data in, MSB first |
| chain_sel | output | 3 | Selected sub-chain; 0 means none |
| port_rst | output | 1 | Internal reset level for the port's registers |
| exec_pulse | output | 1 | One-cycle pulse on an accepted execute frame |
| instr | output | 16 | Instruction word from the last execute frame |
| cmd | output | 8 | Command byte from the last execute frame |

## Verification
The bound checker watches some properties on every cycle:

- `exec_pulse` is single-cycle.
- `instr` and `cmd` move only together with that pulse.
- `chain_sel` stays in range and never changes in the same cycle as an execute.
- `port_rst` only rises with chain one selected.

Other behaviours can only be shown by the bench's framed transfers. These are:

- MSB-first byte assembly.
- Classification by byte count and signature.
- Rejection of bad digits and of wrong lengths.
- Discarding of trailing partial bytes.
- The difference between a true null frame and a frame that only holds a few stray bits.

// File: rtl/dbg_msg_rx.sv
module dbg_msg_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int INSTR_W     = 16,
  parameter int CMD_W       = 8,
  parameter int SEL_W       = 3,
  parameter int MAX_CHAIN   = 6,
  parameter logic [7:0] SIG_SELECT = 8'h53,
  parameter logic [7:0] SIG_EXEC   = 8'h58
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               wr_n,
  input  logic               sdi,
  output logic [SEL_W-1:0]   chain_sel,
  output logic               port_rst,
  output logic               exec_pulse,
  output logic [INSTR_W-1:0] instr,
  output logic [CMD_W-1:0]   cmd
);
  localparam int EXEC_BYTES = INSTR_W/8 + CMD_W/8 + 1;
  localparam int HIST_W     = EXEC_BYTES*8;
  localparam int CNT_W      = $clog2(EXEC_BYTES + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [7:0] DIGIT_LO = 8'h31;
  localparam logic [7:0] DIGIT_HI = 8'(8'h30 + MAX_CHAIN);

  logic [SYNC_STAGES-1:0] sclk_q, wr_q, sdi_q;
  logic sclk_d, wr_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      wr_q   <= '1;
      sdi_q  <= '0;
      sclk_d <= 1'b0;
      wr_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
      wr_q   <= {wr_q[SYNC_STAGES-2:0], wr_n};
      sdi_q  <= {sdi_q[SYNC_STAGES-2:0], sdi};
      sclk_d <= sclk_q[SYNC_STAGES-1];
      wr_d   <= wr_q[SYNC_STAGES-1];
    end

  wire sclk_s = sclk_q[SYNC_STAGES-1];
  wire wr_s   = wr_q[SYNC_STAGES-1];
  wire din    = sdi_q[SYNC_STAGES-1];
  wire wr_fall = wr_d & ~wr_s;
  wire wr_rise = ~wr_d & wr_s;
  wire bit_stb = ~wr_s & sclk_s & ~sclk_d;

  logic [2:0]        bit_idx;
  logic [6:0]        cur;
  logic [CNT_W-1:0]  byte_cnt;
  logic              any_clk;
  logic [HIST_W-1:0] hist;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_idx  <= '0;
      cur      <= '0;
      byte_cnt <= '0;
      any_clk  <= 1'b0;
      hist     <= '0;
    end else if (wr_fall) begin
      bit_idx  <= '0;
      cur      <= '0;
      byte_cnt <= '0;
      any_clk  <= 1'b0;
    end else if (bit_stb) begin
      any_clk <= 1'b1;
      cur     <= {cur[5:0], din};
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7) begin
        hist <= {hist[HIST_W-9:0], cur, din};
        if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
      end
    end

  wire [7:0] sig   = hist[7:0];
  wire [7:0] digit = hist[15:8];
  wire [7:0] chain = digit - 8'h30;

  wire take_null = wr_rise & ~any_clk;
  wire take_sel  = wr_rise & any_clk & (byte_cnt == CNT_W'(2)) & (sig == SIG_SELECT)
                   & (digit >= DIGIT_LO) & (digit <= DIGIT_HI);
  wire take_exec = wr_rise & (byte_cnt == CNT_W'(EXEC_BYTES)) & (sig == SIG_EXEC);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chain_sel  <= '0;
      port_rst   <= 1'b0;
      exec_pulse <= 1'b0;
      instr      <= '0;
      cmd        <= '0;
    end else begin
      exec_pulse <= take_exec;
      if (take_null) begin
        chain_sel <= '0;
        port_rst  <= 1'b0;
      end else if (take_sel) begin
        chain_sel <= chain[SEL_W-1:0];
        if (digit == DIGIT_LO) port_rst <= 1'b1;
      end
      if (take_exec) begin
        instr <= hist[HIST_W-1 -: INSTR_W];
        cmd   <= hist[8 +: CMD_W];
      end
    end
endmodule

module dbg_msg_rx_chk #(
  parameter int INSTR_W   = 16,
  parameter int CMD_W     = 8,
  parameter int SEL_W     = 3,
  parameter int MAX_CHAIN = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SEL_W-1:0]   chain_sel,
  input logic               port_rst,
  input logic               exec_pulse,
  input logic [INSTR_W-1:0] instr,
  input logic [CMD_W-1:0]   cmd
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |=> !exec_pulse);
  // R9
  instr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !exec_pulse) |-> $stable(instr));
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !exec_pulse) |-> $stable(cmd));
  // R4
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_sel <= SEL_W'(MAX_CHAIN));
  // R5
  rst_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $rose(port_rst)) |-> (chain_sel == SEL_W'(1)));
  // R6
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && exec_pulse) |-> $stable(chain_sel));
endmodule

bind dbg_msg_rx dbg_msg_rx_chk #(
  .INSTR_W(INSTR_W), .CMD_W(CMD_W), .SEL_W(SEL_W), .MAX_CHAIN(MAX_CHAIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .port_rst(port_rst),
  .exec_pulse(exec_pulse), .instr(instr), .cmd(cmd)
);

// File: tb/dbg_msg_rx_bench.sv
module dbg_msg_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, wr_n = 1'b1, sdi = 1'b0;
  logic [2:0]  chain_sel;
  logic        port_rst, exec_pulse;
  logic [15:0] instr;
  logic [7:0]  cmd;

  always #4 clk = ~clk;

  dbg_msg_rx u_dbg_msg_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .wr_n(wr_n), .sdi(sdi),
    .chain_sel(chain_sel), .port_rst(port_rst), .exec_pulse(exec_pulse),
    .instr(instr), .cmd(cmd)
  );

  int checks = 0, fails = 0, pulses = 0, cyc = 0;
  logic [7:0]  fb [8];
  logic [2:0]  e_sel = '0;
  logic        e_rst = 1'b0;
  logic [15:0] e_instr = '0;
  logic [7:0]  e_cmd = '0;
  int          e_pul = 0;

  always @(posedge clk) begin
    if (exec_pulse) pulses <= pulses + 1;
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog all-req actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic send(input int nb, input int extra);
    pulses = 0;
    wait_clk(2);
    wr_n = 1'b0;
    wait_clk(5);
    for (int i = 0; i < nb * 8 + extra; i++) begin
      sdi = (i < nb * 8) ? fb[i / 8][7 - (i % 8)] : 1'($urandom);
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
      sclk = 1'b0;
    end
    wait_clk(3);
    wr_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic model(input int nb, input int extra);
    e_pul = 0;
    if (nb == 0 && extra == 0) begin
      e_sel = '0; e_rst = 1'b0;
    end else if (nb == 2 && fb[1] == 8'h53 && fb[0] >= 8'h31 && fb[0] <= 8'h36) begin
      e_sel = 3'(fb[0] - 8'h30);
      if (fb[0] == 8'h31) e_rst = 1'b1;
    end else if (nb == 4 && fb[3] == 8'h58) begin
      e_instr = {fb[0], fb[1]}; e_cmd = fb[2]; e_pul = 1;
    end
  endtask

  task automatic run(input string tag, input int nb, input int extra);
    send(nb, extra);
    model(nb, extra);
    check(tag, "chain_sel", int'(chain_sel), int'(e_sel));
    check(tag, "port_rst", int'(port_rst), int'(e_rst));
    check(tag, "instr", int'(instr), int'(e_instr));
    check(tag, "cmd", int'(cmd), int'(e_cmd));
    check(tag, "pulses", pulses, e_pul);
  endtask

  task automatic set_sel(input logic [7:0] d);
    fb[0] = d; fb[1] = 8'h53;
  endtask

  task automatic set_exec(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    fb[0] = a; fb[1] = b; fb[2] = c; fb[3] = 8'h58;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    // R1
    check("R1", "chain_sel", int'(chain_sel), 0);
    check("R1", "port_rst", int'(port_rst), 0);
    check("R1", "instr", int'(instr), 0);
    check("R1", "cmd", int'(cmd), 0);
    check("R1", "exec_pulse", int'(exec_pulse), 0);

    set_sel(8'h33); run("R4", 2, 0);
    // R2: serial clock while strobe high must be ignored
    for (int i = 0; i < 16; i++) begin
      sdi = 1'($urandom); wait_clk(3); sclk = 1'b1; wait_clk(3); sclk = 1'b0;
    end
    wait_clk(8);
    check("R2", "chain_sel", int'(chain_sel), 3);
    check("R2", "instr", int'(instr), 0);
    set_exec(8'hA5, 8'h3C, 8'h81); run("R2", 4, 0);
    set_exec(8'h12, 8'h34, 8'h06); run("R6", 4, 0);
    set_sel(8'h36); run("R4", 2, 0);
    set_exec(8'hFE, 8'h01, 8'h0A); run("R6", 4, 0);
    set_sel(8'h31); run("R5", 2, 0);
    set_sel(8'h34); run("R5", 2, 0);
    set_exec(8'h00, 8'hFF, 8'h02); run("R5", 4, 0);
    run("R3", 0, 0);
    set_sel(8'h35); run("R8", 2, 0);
    run("R8", 0, 3);
    run("R8", 0, 7);
    set_sel(8'h32); run("R8", 2, 5);
    set_sel(8'h37); run("R7", 2, 0);
    set_sel(8'h30); run("R7", 2, 0);
    set_exec(8'h11, 8'h22, 8'h33); fb[4] = 8'h58; run("R7", 5, 0);
    set_exec(8'h11, 8'h22, 8'h33); fb[3] = 8'h53; run("R7", 4, 0);
    fb[0] = 8'h58; run("R7", 1, 0);
    set_exec(8'h5A, 8'hC3, 8'h04); run("R8", 4, 6);
    run("R3", 0, 0);

    for (int k = 0; k < 60; k++) begin
      int kind;
      kind = int'($urandom % 6);
      case (kind)
        0: run("R3", 0, 0);
        1: begin set_sel(8'(8'h31 + $urandom % 6)); run("R4", 2, 0); end
        2: begin set_exec(8'($urandom), 8'($urandom), 8'($urandom)); run("R6", 4, 0); end
        3: begin set_sel(8'($urandom)); run("R7", 2, 0); end
        4: begin
          int nb;
          nb = int'($urandom % 7);
          for (int j = 0; j < 8; j++) fb[j] = 8'($urandom);
          if (nb > 0 && ($urandom % 2) == 1) fb[nb - 1] = (($urandom % 2) == 1) ? 8'h58 : 8'h53;
          run("R7", nb, 0);
        end
        default: begin
          if (($urandom % 2) == 1) begin
            set_exec(8'($urandom), 8'($urandom), 8'($urandom)); run("R8", 4, 1 + int'($urandom % 7));
          end else begin
            set_sel(8'(8'h31 + $urandom % 6)); run("R8", 2, 1 + int'($urandom % 7));
          end
        end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule